// File: doc/BRIEF.md
# Mode-Banked Register File with Two Read Ports

This block is the integer register storage of a small load/store processor core. It holds sixteen visible 32-bit registers, read through two combinational source ports that feed the operand buses A and B, and written through one synchronous destination port. The active processor mode, an input, picks which physical copy stands behind each visible index. Some indices have hidden copies that are owned by a single mode. The pipeline uses index 13 as the stack pointer, index 14 as the return-address register and index 15 as the program counter. The file treats all three as plain storage.

The block also keeps one current status word, which is the same in every mode, and one saved status word for each exception mode. In total it holds 37 physical words: 31 general registers, five saved status words and one current status word. Twenty of these words are banked. The current status word and the active saved status word, together with the sixteen visible registers, make up the eighteen words that are live at any moment.

Top module: `rbank_regfile`

## Requirements
- R1: After reset every physical word is zero, so every read port returns 0 for every index in every mode.
- R2: The two source ports are independent and combinational. `bus_a` shows the active copy of `src_a_idx` in the same cycle, and `bus_b` shows the active copy of `src_b_idx`.
- R3: When `dst_we` is high at a rising clock edge, `dst_data` is stored in the active copy of `dst_idx`. A read of that index in the same cycle returns the old value. The new value appears from the next cycle.
- R4: Indices 0 to 7 and index 15 are a single shared copy in every mode.
- R5: In the fast-interrupt mode (mode code 1), indices 8 to 14 map to a private copy of seven registers.
- R6: Modes interrupt (2), supervisor (3), abort (4) and undefined (5) each own a private pair for indices 13 and 14. In these modes, indices 8 to 12 are the shared copy.
- R7: User mode (0) and system mode (6) use the same unbanked set. The reserved code 7 behaves like user mode.
- R8: Each of the modes 1 to 5 has its own saved status word. It is written by `ss_we` at a rising edge and is read on `ss_rdata` while that mode is active.
- R9: In modes 0, 6 and 7, `ss_rdata` is zero and `ss_we` changes no stored word.
- R10: The current status word is one word shared by every mode. It is written by `cs_we` at a rising edge and is always visible on `cs_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes happen on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_mode | input | 3 | Active processor mode code (0 user, 1 fast interrupt, 2 interrupt, 3 supervisor, 4 abort, 5 undefined, 6 system, 7 reserved) |
| src_a_idx | input | 4 | Visible index read onto bus A |
| bus_a | output | 32 | Operand bus A |
| src_b_idx | input | 4 | Visible index read onto bus B |
| bus_b | output | 32 | Operand bus B |
| dst_we | input | 1 | Destination write enable |
| dst_idx | input | 4 | Destination visible index |
| dst_data | input | 32 | Destination write data |
| ss_we | input | 1 | Saved status write enable |
| ss_wdata | input | 32 | Saved status write data |
| ss_rdata | output | 32 | Saved status word of the active mode |
| cs_we | input | 1 | Current status write enable |
| cs_wdata | input | 32 | Current status write data |
| cs_rdata | output | 32 | Current status word |

## Verification
The hardest case to reach from the ports is aliasing between modes. A value written under one mode must appear, or stay hidden, when the same index is read under another mode. A bug that maps two banks onto one slot is invisible unless a later write through a different mode lands on the same physical word. The stimulus table therefore interleaves writes to the same index under different modes, including user and system writes that overwrite each other and the reserved code. It then reads every index in all eight modes on both buses and compares each read with a model keyed by owning mode.

// File: rtl/rbank_pkg.sv
package rbank_pkg;
  localparam int NVIS       = 16;
  localparam int IDXW       = $clog2(NVIS);
  localparam int MODEW      = 3;
  localparam int FIQ_LO     = 8;
  localparam int FIQ_HI     = 14;
  localparam int NFIQ       = FIQ_HI - FIQ_LO + 1;
  localparam int PAIR_LO    = 13;
  localparam int NPAIRMODE  = 4;
  localparam int NGPR       = NVIS + NFIQ + 2 * NPAIRMODE;
  localparam int SLOTW      = $clog2(NGPR);
  localparam int NSAVED     = 5;
  localparam int SSW        = $clog2(NSAVED);

  typedef enum logic [MODEW-1:0] {
    M_USR = 3'd0, M_FIQ = 3'd1, M_IRQ = 3'd2, M_SVC = 3'd3,
    M_ABT = 3'd4, M_UND = 3'd5, M_SYS = 3'd6, M_RSV = 3'd7
  } mode_e;

  function automatic logic is_pair_mode(logic [MODEW-1:0] m);
    return (m >= M_IRQ) && (m <= M_UND);
  endfunction

  // visible index -> physical general-register slot
  function automatic logic [SLOTW-1:0] gpr_slot(logic [MODEW-1:0] m, logic [IDXW-1:0] idx);
    logic [SLOTW-1:0] s;
    s = SLOTW'(idx);
    if (m == M_FIQ && idx >= FIQ_LO && idx <= FIQ_HI)
      s = SLOTW'(NVIS + int'(idx) - FIQ_LO);
    else if (is_pair_mode(m) && idx >= PAIR_LO && idx <= PAIR_LO + 1)
      s = SLOTW'(NVIS + NFIQ + 2 * (int'(m) - int'(M_IRQ)) + int'(idx) - PAIR_LO);
    return s;
  endfunction

  function automatic logic has_saved(logic [MODEW-1:0] m);
    return (m >= M_FIQ) && (m <= M_UND);
  endfunction

  function automatic logic [SSW-1:0] saved_slot(logic [MODEW-1:0] m);
    return SSW'(int'(m) - int'(M_FIQ));
  endfunction
endpackage

// File: rtl/rbank_map.sv
module rbank_map
  import rbank_pkg::*;
(
  input  logic [MODEW-1:0] mode,
  input  logic [IDXW-1:0]  idx,
  output logic [SLOTW-1:0] slot
);
  always_comb slot = gpr_slot(mode, idx);
endmodule

// File: rtl/rbank_gpr_store.sv
module rbank_gpr_store
  import rbank_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SLOTW-1:0] wslot,
  input  logic [DW-1:0]    wdata,
  input  logic [SLOTW-1:0] aslot,
  input  logic [SLOTW-1:0] bslot,
  output logic [DW-1:0]    adata,
  output logic [DW-1:0]    bdata,
  output logic [NGPR-1:0]  whot
);
  logic [DW-1:0] regs [NGPR];

  for (genvar s = 0; s < NGPR; s++) begin : g_slot
    assign whot[s] = we && (wslot == SLOTW'(s));
    always_ff @(posedge clk) begin
      if (!rst_n)       regs[s] <= '0;
      else if (whot[s]) regs[s] <= wdata;
    end
  end

  assign adata = regs[aslot];
  assign bdata = regs[bslot];
endmodule

// File: rtl/rbank_status.sv
module rbank_status
  import rbank_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MODEW-1:0] mode,
  input  logic             ss_we,
  input  logic [DW-1:0]    ss_wdata,
  output logic [DW-1:0]    ss_rdata,
  input  logic             cs_we,
  input  logic [DW-1:0]    cs_wdata,
  output logic [DW-1:0]    cs_rdata
);
  logic [DW-1:0] saved [NSAVED];
  logic [DW-1:0] cur;
  logic          ss_ok;

  assign ss_ok = has_saved(mode);

  for (genvar k = 0; k < NSAVED; k++) begin : g_saved
    always_ff @(posedge clk) begin
      if (!rst_n) saved[k] <= '0;
      else if (ss_we && ss_ok && saved_slot(mode) == SSW'(k)) saved[k] <= ss_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     cur <= '0;
    else if (cs_we) cur <= cs_wdata;
  end

  assign ss_rdata = ss_ok ? saved[saved_slot(mode)] : '0;
  assign cs_rdata = cur;
endmodule

// File: rtl/rbank_regfile.sv
module rbank_regfile
  import rbank_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MODEW-1:0] cur_mode,
  input  logic [IDXW-1:0]  src_a_idx,
  output logic [DW-1:0]    bus_a,
  input  logic [IDXW-1:0]  src_b_idx,
  output logic [DW-1:0]    bus_b,
  input  logic             dst_we,
  input  logic [IDXW-1:0]  dst_idx,
  input  logic [DW-1:0]    dst_data,
  input  logic             ss_we,
  input  logic [DW-1:0]    ss_wdata,
  output logic [DW-1:0]    ss_rdata,
  input  logic             cs_we,
  input  logic [DW-1:0]    cs_wdata,
  output logic [DW-1:0]    cs_rdata
);
  localparam int NPORT = 3;
  logic [IDXW-1:0]  port_idx  [NPORT];
  logic [SLOTW-1:0] port_slot [NPORT];
  logic [NGPR-1:0]  wr_hot;

  assign port_idx[0] = src_a_idx;
  assign port_idx[1] = src_b_idx;
  assign port_idx[2] = dst_idx;

  for (genvar p = 0; p < NPORT; p++) begin : g_map
    rbank_map u_map (.mode(cur_mode), .idx(port_idx[p]), .slot(port_slot[p]));
  end

  rbank_gpr_store #(.DW(DW)) u_gpr (
    .clk(clk), .rst_n(rst_n), .we(dst_we), .wslot(port_slot[2]), .wdata(dst_data),
    .aslot(port_slot[0]), .bslot(port_slot[1]), .adata(bus_a), .bdata(bus_b),
    .whot(wr_hot)
  );

  rbank_status #(.DW(DW)) u_stat (
    .clk(clk), .rst_n(rst_n), .mode(cur_mode),
    .ss_we(ss_we), .ss_wdata(ss_wdata), .ss_rdata(ss_rdata),
    .cs_we(cs_we), .cs_wdata(cs_wdata), .cs_rdata(cs_rdata)
  );
endmodule

// File: rtl/rbank_regfile_chk.sv
module rbank_regfile_chk
  import rbank_pkg::*;
#(
  parameter int DW = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [MODEW-1:0] cur_mode,
  input logic [IDXW-1:0]  src_a_idx,
  input logic [DW-1:0]    bus_a,
  input logic             dst_we,
  input logic [IDXW-1:0]  dst_idx,
  input logic [DW-1:0]    dst_data,
  input logic             ss_we,
  input logic [DW-1:0]    ss_wdata,
  input logic [DW-1:0]    ss_rdata,
  input logic             cs_we,
  input logic [DW-1:0]    cs_wdata,
  input logic [DW-1:0]    cs_rdata,
  input logic [NGPR-1:0]  wr_hot
);
  // R3
  wr_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dst_we |=> (!(src_a_idx == $past(dst_idx) && cur_mode == $past(cur_mode))
                || bus_a == $past(dst_data)));

  // R2
  rd_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dst_we |=> (!(src_a_idx == $past(src_a_idx) && cur_mode == $past(cur_mode))
                 || $stable(bus_a)));

  // R3
  one_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dst_we |-> $countones(wr_hot) == 1);

  // R3
  no_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dst_we |-> wr_hot == '0);

  // R9
  ss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !has_saved(cur_mode) |-> ss_rdata == '0);

  // R8
  ss_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_we && has_saved(cur_mode)) |=>
      (cur_mode != $past(cur_mode) || ss_rdata == $past(ss_wdata)));

  // R10
  cs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_we |=> cs_rdata == $past(cs_wdata));
endmodule

bind rbank_regfile rbank_regfile_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cur_mode(cur_mode), .src_a_idx(src_a_idx), .bus_a(bus_a),
  .dst_we(dst_we), .dst_idx(dst_idx), .dst_data(dst_data),
  .ss_we(ss_we), .ss_wdata(ss_wdata), .ss_rdata(ss_rdata),
  .cs_we(cs_we), .cs_wdata(cs_wdata), .cs_rdata(cs_rdata), .wr_hot(wr_hot)
);

// File: tb/rbank_regfile_test.sv
`timescale 1ns/1ps
module rbank_regfile_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [2:0]  cur_mode = 0;
  logic [3:0]  src_a_idx = 0, src_b_idx = 0, dst_idx = 0;
  logic [31:0] bus_a, bus_b, dst_data = 0, ss_wdata = 0, ss_rdata, cs_wdata = 0, cs_rdata;
  logic        dst_we = 0, ss_we = 0, cs_we = 0;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  rbank_regfile uut (
    .clk(clk), .rst_n(rst_n), .cur_mode(cur_mode),
    .src_a_idx(src_a_idx), .bus_a(bus_a), .src_b_idx(src_b_idx), .bus_b(bus_b),
    .dst_we(dst_we), .dst_idx(dst_idx), .dst_data(dst_data),
    .ss_we(ss_we), .ss_wdata(ss_wdata), .ss_rdata(ss_rdata),
    .cs_we(cs_we), .cs_wdata(cs_wdata), .cs_rdata(cs_rdata)
  );

  // model: storage keyed by owning mode and index
  logic [31:0] m_gpr [8][16];
  logic [31:0] m_ss [8];

  function automatic int owner(input int m, input int i);
    case (m)
      1:       return (i >= 8 && i <= 14) ? 1 : 0;
      2, 3, 4, 5: return (i == 13 || i == 14) ? m : 0;
      default: return 0;
    endcase
  endfunction

  localparam logic [38:0] VEC [12] = '{
    {3'd0, 4'd3,  32'h1111_0003}, {3'd1, 4'd3,  32'h2222_0003},
    {3'd1, 4'd8,  32'hF1F1_0008}, {3'd0, 4'd8,  32'h0B0B_0008},
    {3'd2, 4'd13, 32'hC2C2_000D}, {3'd3, 4'd13, 32'hD3D3_000D},
    {3'd4, 4'd14, 32'hE4E4_000E}, {3'd5, 4'd14, 32'hF5F5_000E},
    {3'd6, 4'd13, 32'h6666_000D}, {3'd1, 4'd13, 32'h1F1F_000D},
    {3'd7, 4'd9,  32'h7777_0009}, {3'd3, 4'd15, 32'hABCD_000F}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] m, input logic [3:0] i, input logic [31:0] d);
    @(negedge clk);
    cur_mode = m; dst_idx = i; dst_data = d; dst_we = 1;
    @(negedge clk);
    dst_we = 0;
    m_gpr[owner(int'(m), int'(i))][i] = d;
  endtask

  task automatic rd(input string req, input logic [2:0] m, input logic [3:0] ia, input logic [3:0] ib);
    cur_mode = m; src_a_idx = ia; src_b_idx = ib;
    #2;
    chk({req, " bus_a"}, bus_a, m_gpr[owner(int'(m), int'(ia))][ia]);
    chk({req, " bus_b"}, bus_b, m_gpr[owner(int'(m), int'(ib))][ib]);
  endtask

  task automatic clear_model();
    for (int m = 0; m < 8; m++) begin
      m_ss[m] = 0;
      for (int i = 0; i < 16; i++) m_gpr[m][i] = 0;
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clear_model();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state on both buses and status words
    for (int m = 0; m < 8; m++) rd("R1", 3'(m), 4'd13, 4'd8);
    chk("R1 cs", cs_rdata, 0);
    cur_mode = 3'd3; #2; chk("R1 ss", ss_rdata, 0);

    // table walk: R4 R5 R6 R7 aliasing across modes
    for (int k = 0; k < 12; k++) wr(VEC[k][38:36], VEC[k][35:32], VEC[k][31:0]);
    @(negedge clk);
    for (int m = 0; m < 8; m++)
      for (int i = 0; i < 16; i++) rd("R2 R4 R5 R6 R7", 3'(m), 4'(i), 4'(15 - i));

    // direct spot checks against fixed values
    cur_mode = 3'd6; src_a_idx = 4'd13; src_b_idx = 4'd3; #2;
    chk("R7 sys sees user r13", bus_a, 32'h6666_000D);
    chk("R4 r3 shared", bus_b, 32'h2222_0003);
    cur_mode = 3'd2; src_a_idx = 4'd8; src_b_idx = 4'd15; #2;
    chk("R6 irq r8 shared", bus_a, 32'h0B0B_0008);
    chk("R4 r15 shared", bus_b, 32'hABCD_000F);
    cur_mode = 3'd1; src_a_idx = 4'd9; #2;
    chk("R5 fiq r9 private", bus_a, 32'h0);

    // R3: same-cycle read returns old, next cycle new
    @(negedge clk);
    cur_mode = 3'd0; dst_idx = 4'd5; dst_data = 32'h5A5A_A5A5; dst_we = 1;
    src_a_idx = 4'd5; src_b_idx = 4'd5;
    #2;
    chk("R3 old on bus_a", bus_a, 32'h0);
    chk("R3 old on bus_b", bus_b, 32'h0);
    @(posedge clk); #2;
    chk("R3 new on bus_a", bus_a, 32'h5A5A_A5A5);
    @(negedge clk); dst_we = 0;

    // R8: saved status per exception mode
    for (int m = 1; m <= 5; m++) begin
      @(negedge clk);
      cur_mode = 3'(m); ss_wdata = 32'h5500_0000 | 32'(m); ss_we = 1;
      @(negedge clk); ss_we = 0;
      m_ss[m] = 32'h5500_0000 | 32'(m);
    end
    // R9: writes in modes without a saved word are dropped
    foreach (m_ss[m]) if (m == 0 || m == 6 || m == 7) begin
      @(negedge clk);
      cur_mode = 3'(m); ss_wdata = 32'hDEAD_0000 | 32'(m); ss_we = 1;
      @(negedge clk); ss_we = 0;
    end
    for (int m = 0; m < 8; m++) begin
      cur_mode = 3'(m); #2;
      chk((m >= 1 && m <= 5) ? "R8 saved" : "R9 saved zero", ss_rdata, m_ss[m]);
    end

    // R10: current status is mode independent
    @(negedge clk);
    cur_mode = 3'd4; cs_wdata = 32'h0000_00D3; cs_we = 1;
    @(negedge clk); cs_we = 0;
    for (int m = 0; m < 8; m++) begin
      cur_mode = 3'(m); #2; chk("R10 cs", cs_rdata, 32'h0000_00D3);
    end

    // R1: reset again clears everything
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    clear_model();
    for (int m = 0; m < 8; m++) rd("R1 after reset", 3'(m), 4'd14, 4'd3);
    cur_mode = 3'd1; #2; chk("R1 ss after reset", ss_rdata, 0);
    chk("R1 cs after reset", cs_rdata, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule